// File: doc/BRIEF.md
# Infrared pulse-timing code receiver

This block turns a demodulated infrared line into a received code word of up to 64 bits. It measures the length of each mark (active level) and the space that follows it in system clock cycles. Each mark-plus-space pair is one symbol. The block compares every symbol against programmable min/max windows for its whole period and for its mark width. An optional start symbol opens the frame. After that, each data symbol yields one bit. The frame closes when the line stays inactive for longer than a programmed free time.

A closed frame is reported only if its bit count lies inside programmed even-valued length limits. The word appears as two 32-bit halves with its length. A sticky valid flag and a one-cycle done pulse go with it. A reported word is protected: a later frame cannot overwrite it until both halves have been acknowledged as read.

Configuration is a set of static, register-style inputs. Software changes them only while the line is idle.

Top module: `ir_pulse_rx`

## Requirements
- R1: Start symbol windows (`ldr_win_i`) are counted in units of 16 cycles. Field layout, from bit 0 upward in WIN_W-bit fields: width min, width max, period min, period max. With the start symbol enabled, the first symbol of a frame is accepted only if 16·wmin ≤ mark ≤ 16·wmax and 16·pmin ≤ mark+space ≤ 16·pmax.
- R2: Each of the four data windows (`sym_win_i`, window k at bits [k·4·WIN_W +: 4·WIN_W], same field layout as R1) counts width in single cycles and period in units of 2 cycles. Windows 0 and 2 decode a 0 and windows 1 and 3 decode a 1. When several windows match, the lowest index wins.
- R3: A frame ends once the inactive run after a mark reaches 8·`ft_min_i`+1 cycles. An inactive run of exactly 8·`ft_min_i` cycles does not end it. The mark before the closing idle is not decoded as a bit.
- R4: A frame is reported only if it has at least one bit and its length n satisfies minL ≤ n ≤ maxL. Here minL is `min_len_i` with bit 0 forced to 0, and maxL is `max_len_i` with bit 0 forced to 0, capped at 48.
- R5: `ctrl_i[1]`=1 enables the start symbol. With it at 0, the first symbol is already a data symbol.
- R6: `ctrl_i[2]`=1 inverts the line, so a low input is a mark.
- R7: `ctrl_i[3]`=0 places the k-th received bit at bit k. With `ctrl_i[3]`=1 the first bit lands at bit n−1 and the last at bit 0.
- R8: `ctrl_i[4]`=1 inverts every decoded bit.
- R9: A symbol matching no required window aborts the frame. No report follows, and the receiver waits for an idle run as in R3 before it accepts a new frame.
- R10: The mark counter saturates at its all-ones value instead of wrapping.
- R11: A report raises `done_o` for one cycle and sets `valid_o`. `valid_o` stays set until `vld_clr_i` is pulsed.
- R12: After a report, words, length and valid are frozen against new frames until both `rd_lo_i` and `rd_hi_i` have been pulsed. A frame completing before then is dropped.
- R13: `ctrl_i[0]`=0 holds the receiver idle. `ctrl_i` all zero also clears valid, the stored words, the length and the read protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 5 | Enable, start-symbol enable, line invert, MSB-first, bit invert |
| ldr_win_i | input | 4·WIN_W | Start symbol windows (units of 16 cycles) |
| sym_win_i | input | 16·WIN_W | Four data symbol windows |
| ft_min_i | input | FT_W | Free-time threshold in units of 8 cycles |
| min_len_i | input | 5 | Minimum frame length (bit 0 ignored) |
| max_len_i | input | 6 | Maximum frame length (bit 0 ignored, cap 48) |
| ir_i | input | 1 | Demodulated infrared line |
| rd_lo_i | input | 1 | Low word read acknowledge pulse |
| rd_hi_i | input | 1 | High word read acknowledge pulse |
| vld_clr_i | input | 1 | Clears the valid flag |
| data_lo_o | output | 32 | Received word bits 31:0 |
| data_hi_o | output | 32 | Received word bits 63:32 |
| len_o | output | 7 | Received bit count |
| valid_o | output | 1 | Sticky valid flag |
| done_o | output | 1 | One-cycle report pulse |

## Verification
The bench keeps the defaults WIN_W=8, CNT_W=14 and FT_W=10, and programs small window values. Each symbol then lasts only tens of cycles, and a 48- or 50-bit frame fits easily in the run. The 14-bit mark counter lets a 20000-cycle mark cross its all-ones limit. With the start windows set around 3616 cycles, a wrapped counter would be accepted and a saturated one rejected. The scaled window units permit exact edge tests: a width of 16·wmax against 16·wmax+1, a data width of wmax against wmax+1, and an idle run of 8·ft_min against 8·ft_min+1 inside a frame.

// File: rtl/ir_pulse_rx.sv
`timescale 1ns/1ps
module ir_pulse_rx #(
  parameter int WIN_W = 8,
  parameter int CNT_W = 14,
  parameter int FT_W  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           ctrl_i,
  input  logic [4*WIN_W-1:0]   ldr_win_i,
  input  logic [16*WIN_W-1:0]  sym_win_i,
  input  logic [FT_W-1:0]      ft_min_i,
  input  logic [4:0]           min_len_i,
  input  logic [5:0]           max_len_i,
  input  logic                 ir_i,
  input  logic                 rd_lo_i,
  input  logic                 rd_hi_i,
  input  logic                 vld_clr_i,
  output logic [31:0]          data_lo_o,
  output logic [31:0]          data_hi_o,
  output logic [6:0]           len_o,
  output logic                 valid_o,
  output logic                 done_o
);
  localparam int PW    = CNT_W + 1;
  localparam int AW    = (PW > WIN_W + 4) ? PW : WIN_W + 4;
  localparam int XW    = ((AW > FT_W + 3) ? AW : FT_W + 3) + 1;
  localparam int SYM_N = 4;
  localparam int WINB  = 4 * WIN_W;
  localparam logic [5:0] LEN_CAP = 6'd48;
  localparam logic [6:0] BIT_CAP = 7'd64;

  typedef enum logic [1:0] {S_IDLE, S_MARK, S_SPACE, S_SYNC} st_t;

  st_t              st_q;
  logic             sy1_q, sy2_q;
  logic [CNT_W-1:0] mark_q, space_q;
  logic             first_q;
  logic [6:0]       nbits_q;
  logic [63:0]      sh_q, data_q;
  logic [6:0]       len_q;
  logic             valid_q, lock_q, seen_lo_q, seen_hi_q, done_q;

  wire en       = ctrl_i[0];
  wire ldr_en   = ctrl_i[1];
  wire ctrl_off = (ctrl_i == 5'd0);
  wire line     = sy2_q ^ ctrl_i[2];

  wire [CNT_W-1:0] mark_inc  = (&mark_q)  ? mark_q  : mark_q + 1'b1;
  wire [CNT_W-1:0] space_inc = (&space_q) ? space_q : space_q + 1'b1;
  wire [PW-1:0]    period    = {1'b0, mark_q} + {1'b0, space_q};
  wire [XW-1:0]    w_x       = XW'(mark_q);
  wire [XW-1:0]    pd_x      = XW'(period);
  wire [XW-1:0]    ft_thr    = XW'(ft_min_i) << 3;
  wire             ft_hit    = XW'(space_q) >= ft_thr;

  wire [WIN_W-1:0] l_wmn = ldr_win_i[0*WIN_W +: WIN_W];
  wire [WIN_W-1:0] l_wmx = ldr_win_i[1*WIN_W +: WIN_W];
  wire [WIN_W-1:0] l_pmn = ldr_win_i[2*WIN_W +: WIN_W];
  wire [WIN_W-1:0] l_pmx = ldr_win_i[3*WIN_W +: WIN_W];
  wire ldr_ok = (w_x  >= (XW'(l_wmn) << 4)) && (w_x  <= (XW'(l_wmx) << 4)) &&
                (pd_x >= (XW'(l_pmn) << 4)) && (pd_x <= (XW'(l_pmx) << 4));

  logic [SYM_N-1:0] hit;
  for (genvar k = 0; k < SYM_N; k++) begin : g_sym
    wire [WIN_W-1:0] wmn = sym_win_i[k*WINB + 0*WIN_W +: WIN_W];
    wire [WIN_W-1:0] wmx = sym_win_i[k*WINB + 1*WIN_W +: WIN_W];
    wire [WIN_W-1:0] pmn = sym_win_i[k*WINB + 2*WIN_W +: WIN_W];
    wire [WIN_W-1:0] pmx = sym_win_i[k*WINB + 3*WIN_W +: WIN_W];
    assign hit[k] = (w_x  >= XW'(wmn)) && (w_x <= XW'(wmx)) &&
                    (pd_x >= (XW'(pmn) << 1)) && (pd_x <= (XW'(pmx) << 1));
  end

  wire any_hit = |hit;
  wire raw_bit = !hit[0] && (hit[1] || (!hit[2] && hit[3]));
  wire bit_val = raw_bit ^ ctrl_i[4];
  wire [63:0] sh_next = ctrl_i[3] ? {sh_q[62:0], bit_val}
                                  : (sh_q | (64'(bit_val) << nbits_q[5:0]));

  wire [4:0] min_eff = {min_len_i[4:1], 1'b0};
  wire [5:0] max_eff = (max_len_i > LEN_CAP) ? LEN_CAP : {max_len_i[5:1], 1'b0};
  wire len_ok   = (nbits_q != 7'd0) && (nbits_q >= 7'(min_eff)) && (nbits_q <= 7'(max_eff));
  wire frame_ok = en && (st_q == S_SPACE) && !line && ft_hit &&
                  !(first_q && ldr_en) && len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 1'b0;
      sy2_q <= 1'b0;
    end else begin
      sy1_q <= ir_i;
      sy2_q <= sy1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      mark_q  <= '0;
      space_q <= '0;
      first_q <= 1'b1;
      nbits_q <= '0;
      sh_q    <= '0;
    end else if (!en) begin
      st_q    <= S_IDLE;
      mark_q  <= '0;
      space_q <= '0;
      first_q <= 1'b1;
      nbits_q <= '0;
      sh_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (line) begin
          st_q    <= S_MARK;
          mark_q  <= CNT_W'(1);
          space_q <= '0;
          first_q <= 1'b1;
          nbits_q <= '0;
          sh_q    <= '0;
        end
        S_MARK: if (line) mark_q <= mark_inc;
                else begin
                  st_q    <= S_SPACE;
                  space_q <= CNT_W'(1);
                end
        S_SPACE: if (line) begin
          if (first_q && ldr_en) begin
            if (ldr_ok) begin
              first_q <= 1'b0;
              st_q    <= S_MARK;
              mark_q  <= CNT_W'(1);
              space_q <= '0;
            end else begin
              st_q    <= S_SYNC;
              space_q <= '0;
            end
          end else if (any_hit && nbits_q != BIT_CAP) begin
            sh_q    <= sh_next;
            nbits_q <= nbits_q + 1'b1;
            first_q <= 1'b0;
            st_q    <= S_MARK;
            mark_q  <= CNT_W'(1);
            space_q <= '0;
          end else begin
            st_q    <= S_SYNC;
            space_q <= '0;
          end
        end else if (ft_hit) st_q <= S_IDLE;
        else space_q <= space_inc;
        S_SYNC: if (line) space_q <= '0;
                else if (ft_hit) st_q <= S_IDLE;
                else space_q <= space_inc;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; len_q <= '0; valid_q <= 1'b0; lock_q <= 1'b0;
      seen_lo_q <= 1'b0; seen_hi_q <= 1'b0; done_q <= 1'b0;
    end else if (ctrl_off) begin
      data_q <= '0; len_q <= '0; valid_q <= 1'b0; lock_q <= 1'b0;
      seen_lo_q <= 1'b0; seen_hi_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (frame_ok && !lock_q) begin
        data_q    <= sh_q;
        len_q     <= nbits_q;
        valid_q   <= 1'b1;
        lock_q    <= 1'b1;
        seen_lo_q <= 1'b0;
        seen_hi_q <= 1'b0;
        done_q    <= 1'b1;
      end else begin
        if (vld_clr_i) valid_q <= 1'b0;
        if (lock_q) begin
          if ((seen_lo_q | rd_lo_i) && (seen_hi_q | rd_hi_i)) begin
            lock_q    <= 1'b0;
            seen_lo_q <= 1'b0;
            seen_hi_q <= 1'b0;
          end else begin
            seen_lo_q <= seen_lo_q | rd_lo_i;
            seen_hi_q <= seen_hi_q | rd_hi_i;
          end
        end
      end
    end
  end

  assign data_lo_o = data_q[31:0];
  assign data_hi_o = data_q[63:32];
  assign len_o     = len_q;
  assign valid_o   = valid_q;
  assign done_o    = done_q;
endmodule

// File: rtl/ir_pulse_rx_chk.sv
`timescale 1ns/1ps
module ir_pulse_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  ctrl_i,
  input logic [4:0]  min_len_i,
  input logic [5:0]  max_len_i,
  input logic [31:0] data_lo_o,
  input logic [31:0] data_hi_o,
  input logic [6:0]  len_o,
  input logic        valid_o,
  input logic        done_o,
  input logic        lock,
  input logic        in_mark,
  input logic        mark_full
);
  p_done_sets_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> valid_o);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_len_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_o >= 7'({$past(min_len_i[4:1]), 1'b0})) && (len_o <= 7'd48) &&
               (len_o <= 7'({$past(max_len_i[5:1]), 1'b0})) && (len_o != 7'd0));

  p_locked_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock) && $past(ctrl_i) != 5'd0) |-> ($stable(data_lo_o) && $stable(data_hi_o)));

  p_zero_ctrl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_i) == 5'd0) |-> (!valid_o && !done_o && len_o == 7'd0));

  p_mark_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mark_full) && $past(in_mark) && in_mark) |-> mark_full);
endmodule

bind ir_pulse_rx ir_pulse_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .min_len_i(min_len_i),
  .max_len_i(max_len_i), .data_lo_o(data_lo_o), .data_hi_o(data_hi_o),
  .len_o(len_o), .valid_o(valid_o), .done_o(done_o), .lock(lock_q),
  .in_mark(st_q == S_MARK), .mark_full(&mark_q)
);

// File: tb/ir_pulse_rx_tb_top.sv
`timescale 1ns/1ps
module ir_pulse_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]   ctrl = 5'd0;
  logic [31:0]  ldr_win;
  logic [127:0] sym_win;
  logic [9:0]   ft = 10'd8;
  logic [4:0]   minl = 5'd4;
  logic [5:0]   maxl = 6'd16;
  logic ir_i = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0, vclr = 1'b0;
  logic [31:0] dlo, dhi;
  logic [6:0]  len;
  logic        valid, done;

  localparam logic [31:0] LDR_W = {8'd6, 8'd4, 8'd4, 8'd2};
  localparam logic [31:0] SW0 = {8'd9, 8'd7, 8'd10, 8'd6};
  localparam logic [31:0] SW1 = {8'd17, 8'd15, 8'd10, 8'd6};
  localparam logic [31:0] SW2 = {8'd15, 8'd13, 8'd22, 8'd18};
  localparam logic [31:0] SW3 = {8'd21, 8'd19, 8'd22, 8'd18};

  ir_pulse_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .ldr_win_i(ldr_win), .sym_win_i(sym_win),
    .ft_min_i(ft), .min_len_i(minl), .max_len_i(maxl), .ir_i(ir_i), .rd_lo_i(rd_lo),
    .rd_hi_i(rd_hi), .vld_clr_i(vclr), .data_lo_o(dlo), .data_hi_o(dhi), .len_o(len),
    .valid_o(valid), .done_o(done));

  int n_run = 0, n_fail = 0, dcnt = 0;
  logic pol = 1'b0;
  int z_mark = 8, z_space = 8, l_mark = 48, l_space = 24;

  always @(posedge clk) if (done) dcnt <= dcnt + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    ir_i = v ^ pol;
    repeat (n) @(negedge clk);
  endtask

  task automatic sym(input int m, input int s);
    drive(1'b1, m);
    drive(1'b0, s);
  endtask

  task automatic send_bit(input logic b, input logic alt);
    if (alt) begin
      if (b) sym(20, 20); else sym(20, 8);
    end else begin
      if (b) sym(8, 24); else sym(z_mark, z_space);
    end
  endtask

  task automatic frame(input logic ldr, input int n, input logic [63:0] bits, input logic alt);
    if (ldr) sym(l_mark, l_space);
    for (int i = 0; i < n; i++) send_bit(bits[i], alt);
    drive(1'b1, 8);
    drive(1'b0, 100);
  endtask

  task automatic ack();
    rd_lo = 1'b1; @(negedge clk);
    rd_lo = 1'b0; rd_hi = 1'b1; @(negedge clk);
    rd_hi = 1'b0; vclr = 1'b1; @(negedge clk);
    vclr = 1'b0;
  endtask

  function automatic logic [63:0] msk(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic expect_rep(input string tag, input int d0, input logic [63:0] exp, input int n);
    chk({tag, " done count"}, 64'(dcnt - d0), 64'd1);
    chk({tag, " data"}, {dhi, dlo}, exp);
    chk({tag, " length"}, 64'(len), 64'(n));
    chk({tag, " valid"}, 64'(valid), 64'd1);
    ack();
  endtask

  task automatic expect_none(input string tag, input int d0);
    chk({tag, " no report"}, 64'(dcnt - d0), 64'd0);
  endtask

  task automatic t_reset();
    chk("R11 reset valid", 64'(valid), 64'd0);
    chk("R11 reset done", 64'(done), 64'd0);
    chk("R13 reset data", {dhi, dlo}, 64'd0);
    chk("R13 reset length", 64'(len), 64'd0);
  endtask

  task automatic t_basic();
    int d0 = dcnt;
    frame(1'b1, 8, 64'hA5, 1'b0);
    expect_rep("R1 R2 R3 basic lsb-first", d0, 64'hA5, 8);
    d0 = dcnt;
    frame(1'b1, 12, 64'h3C6, 1'b0);
    expect_rep("R2 R3 basic 12 bits", d0, 64'h3C6, 12);
  endtask

  task automatic t_lock();
    int d0 = dcnt;
    frame(1'b1, 8, 64'hA5, 1'b0);
    chk("R11 first report", 64'(dcnt - d0), 64'd1);
    frame(1'b1, 8, 64'h3C, 1'b0);
    chk("R12 locked frame dropped", 64'(dcnt - d0), 64'd1);
    chk("R12 data kept", {dhi, dlo}, 64'hA5);
    chk("R11 valid sticky", 64'(valid), 64'd1);
    rd_lo = 1'b1; @(negedge clk); rd_lo = 1'b0;
    vclr = 1'b1; @(negedge clk); vclr = 1'b0;
    chk("R11 valid cleared", 64'(valid), 64'd0);
    frame(1'b1, 8, 64'h3C, 1'b0);
    chk("R12 one half read still locked", 64'(dcnt - d0), 64'd1);
    chk("R12 data kept after low read", {dhi, dlo}, 64'hA5);
    rd_hi = 1'b1; @(negedge clk); rd_hi = 1'b0;
    d0 = dcnt;
    frame(1'b1, 8, 64'h3C, 1'b0);
    expect_rep("R12 unlocked overwrite", d0, 64'h3C, 8);
  endtask

  task automatic t_msb();
    int d0 = dcnt;
    logic [63:0] bits = 64'h53, exp = '0;
    for (int i = 0; i < 8; i++) exp[7-i] = bits[i];
    ctrl = 5'b01011;
    frame(1'b1, 8, bits, 1'b0);
    expect_rep("R7 msb-first", d0, exp, 8);
    ctrl = 5'b00011;
  endtask

  task automatic t_inv();
    int d0 = dcnt;
    ctrl = 5'b10011;
    frame(1'b1, 8, 64'hA5, 1'b0);
    expect_rep("R8 bit invert", d0, 64'h5A, 8);
    ctrl = 5'b00011;
  endtask

  task automatic t_pol();
    int d0;
    ctrl = 5'b00100; pol = 1'b1;
    drive(1'b0, 10);
    ctrl = 5'b00111;
    drive(1'b0, 10);
    d0 = dcnt;
    frame(1'b1, 8, 64'hC3, 1'b0);
    expect_rep("R6 inverted line", d0, 64'hC3, 8);
    ctrl = 5'b00000; pol = 1'b0;
    drive(1'b0, 10);
    ctrl = 5'b00011;
  endtask

  task automatic t_leader_mode();
    int d0 = dcnt;
    ctrl = 5'b00001;
    frame(1'b0, 8, 64'h96, 1'b0);
    expect_rep("R5 leader disabled", d0, 64'h96, 8);
    ctrl = 5'b00011;
    d0 = dcnt;
    frame(1'b0, 8, 64'h96, 1'b0);
    expect_none("R5 R9 missing leader", d0);
  endtask

  task automatic t_bounds();
    int d0 = dcnt;
    z_mark = 10; z_space = 6;
    frame(1'b1, 8, 64'hA4, 1'b0);
    expect_rep("R2 width at max", d0, 64'hA4, 8);
    d0 = dcnt;
    z_mark = 11; z_space = 5;
    frame(1'b1, 8, 64'hA4, 1'b0);
    expect_none("R9 width above max aborts", d0);
    z_mark = 8; z_space = 8;
    d0 = dcnt;
    l_mark = 64;
    frame(1'b1, 8, 64'h71, 1'b0);
    expect_rep("R1 leader width 16*max", d0, 64'h71, 8);
    d0 = dcnt;
    l_mark = 65;
    frame(1'b1, 8, 64'h71, 1'b0);
    expect_none("R1 leader width 16*max+1", d0);
    l_mark = 48;
  endtask

  task automatic t_alt_prio();
    int d0 = dcnt;
    frame(1'b1, 8, 64'h6B, 1'b1);
    expect_rep("R2 windows 2 and 3", d0, 64'h6B, 8);
    sym_win = {SW3, SW1, SW1, SW0};
    d0 = dcnt;
    frame(1'b1, 8, 64'h6B, 1'b0);
    expect_rep("R2 lowest window wins", d0, 64'h6B, 8);
    sym_win = {SW3, SW2, SW1, SW0};
  endtask

  task automatic t_len();
    int d0 = dcnt;
    frame(1'b1, 2, 64'h3, 1'b0);
    expect_none("R4 below min", d0);
    minl = 5'd5; d0 = dcnt;
    frame(1'b1, 4, 64'hB, 1'b0);
    expect_rep("R4 min bit0 ignored", d0, 64'hB, 4);
    minl = 5'd4; maxl = 6'd17; d0 = dcnt;
    frame(1'b1, 16, 64'hBEEF, 1'b0);
    expect_rep("R4 at max", d0, 64'hBEEF, 16);
    d0 = dcnt;
    frame(1'b1, 18, 64'h2BEEF, 1'b0);
    expect_none("R4 max bit0 ignored", d0);
    maxl = 6'd63; d0 = dcnt;
    frame(1'b1, 48, 64'h1234_5678_9ABC, 1'b0);
    expect_rep("R4 cap 48 accepted", d0, 64'h1234_5678_9ABC & msk(48), 48);
    d0 = dcnt;
    frame(1'b1, 50, 64'h3_1234_5678_9ABC, 1'b0);
    expect_none("R4 cap 48 rejects 50", d0);
    maxl = 6'd16;
  endtask

  task automatic t_ft(input int gap, input logic [63:0] exp, input int n, input string tag);
    int d0 = dcnt;
    sym_win = {{8'd43, 8'd40, 8'd22, 8'd18}, SW2, SW1, SW0};
    sym(l_mark, l_space);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    sym(20, gap);
    send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    drive(1'b1, 8);
    drive(1'b0, 100);
    expect_rep(tag, d0, exp, n);
    sym_win = {SW3, SW2, SW1, SW0};
  endtask

  task automatic t_sat();
    int d0 = dcnt;
    ldr_win = {8'd255, 8'd200, 8'd255, 8'd200};
    l_mark = 3616;
    frame(1'b1, 8, 64'h5E, 1'b0);
    expect_rep("R10 long leader in window", d0, 64'h5E, 8);
    d0 = dcnt;
    l_mark = 20000;
    frame(1'b1, 8, 64'h5E, 1'b0);
    expect_none("R10 saturated mark rejected", d0);
    ldr_win = LDR_W; l_mark = 48;
  endtask

  task automatic t_ctrl();
    int d0 = dcnt;
    ctrl = 5'b00010;
    frame(1'b1, 8, 64'hA5, 1'b0);
    expect_none("R13 decode disabled", d0);
    ctrl = 5'b00011; d0 = dcnt;
    frame(1'b1, 8, 64'hE7, 1'b0);
    chk("R13 report before clear", 64'(dcnt - d0), 64'd1);
    ctrl = 5'b00000; @(negedge clk);
    chk("R13 zero ctrl clears valid", 64'(valid), 64'd0);
    chk("R13 zero ctrl clears data", {dhi, dlo}, 64'd0);
    chk("R13 zero ctrl clears length", 64'(len), 64'd0);
    ctrl = 5'b00011; d0 = dcnt;
    frame(1'b1, 8, 64'h18, 1'b0);
    expect_rep("R13 lock released by zero ctrl", d0, 64'h18, 8);
  endtask

  initial begin
    ldr_win = LDR_W;
    sym_win = {SW3, SW2, SW1, SW0};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    ctrl = 5'b00011;
    drive(1'b0, 10);
    t_basic();
    t_lock();
    t_msb();
    t_inv();
    t_pol();
    t_leader_mode();
    t_bounds();
    t_alt_prio();
    t_len();
    t_ft(64, 64'h9D, 8, "R3 idle of 8*ft inside frame");
    t_ft(65, 64'hD, 4, "R3 idle of 8*ft+1 closes frame");
    t_sat();
    t_ctrl();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 180000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule